// File: doc/BRIEF.md
# Instruction cycle count timer

This block paces an 8-bit CPU one instruction at a time. When the sequencer fetches an opcode it raises `start` with the opcode on `opcode`. The block decodes how many bytes the instruction occupies and how many clock cycles it needs. It holds `busy` high for that many cycles and pulses `last_cycle` on the final one, so the sequencer knows when to fetch the next opcode.

The count depends on more than the opcode. Decimal-mode arithmetic adds a cycle. Indexed reads that cross a page add a cycle. Conditional branches grow from 2 cycles to 3 when taken, or to 4 when the target lies in another page.

The block does no address or ALU work. It only supplies cycle-accurate timing, for example in an emulator timing model. Cycle 1 of an instruction is the cycle in which `start` is accepted.

Top module: `insn_cycle_timer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy` and `last_cycle` are 0 and `len_bytes` is 0.
- R2: Every opcode whose low nibble is 3, 7, B or F is a 1-byte, 1-cycle no-operation: `last_cycle` rises in the same cycle as the accepted `start`.
- R3: Low nibble 2 with an even high nibble (except A2) is a 2-byte, 2-cycle no-operation. Low nibble 2 with an odd high nibble is a 2-byte indirect access of 5 cycles. A2 is 2 bytes and 2 cycles.
- R4: `busy` is high from the accepted `start` through the final cycle. `last_cycle` pulses exactly once, on that final cycle, and `busy` is low in the next cycle unless a new `start` arrives.
- R5: A `start` that arrives while an instruction still has cycles to run is ignored: the running count and `len_bytes` are unchanged.
- R6: Add and subtract opcodes take one extra cycle when `dec_mode` is 1 in cycle 1. These are the opcodes with high nibble 6, 7, E or F and low nibble 1, 5, 9 or D, plus 72 and F2.
- R7: Indexed and indirect-indexed reads take one extra cycle when `page_cross` is 1. These are 11, 31, …, F1 except 91; 19, …, F9 except 99; 1D, …, FD except 9D; and 3C, BC and BE. `page_cross` is sampled only in the cycle that would otherwise be the last.
- R8: Conditional branches (low nibble 0, odd high nibble) take 2 cycles when `br_taken` is 0. When `br_taken` is 1 they take 3 cycles, or 4 if `br_far` is also 1. Both flags are sampled in cycle 2 only.
- R9: Opcode 80 is an unconditional branch of 3 cycles, or 4 when `br_far` is 1 in cycle 2.
- R10: 00 takes 7 cycles and 1 byte. 20 takes 6 cycles and 3 bytes. 40 and 60 take 6 cycles and 1 byte each.
- R11: The pushes 48, 5A and DA take 3 cycles. The pulls 68, 7A and FA take 4 cycles. All six are 1 byte.
- R12: 4C takes 3 cycles. 6C and 7C take 6 cycles. All three are 3 bytes.
- R13: The stores 91 (6 cycles), 99 (5 cycles) and 9D (5 cycles) ignore `page_cross`.
- R14: `len_bytes` gives the decoded length from the cycle of the accepted `start` until the next accepted `start`. Examples: A9 is 2 bytes in 2 cycles, AD is 3 bytes in 4, 0E is 3 bytes in 6, and 5C is 3 bytes in 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opcode fetch cycle; accepted only when idle or in the final cycle of a 1-cycle op |
| opcode | input | 8 | Opcode fetched in the `start` cycle |
| dec_mode | input | 1 | Decimal-mode flag, sampled in cycle 1 |
| page_cross | input | 1 | Effective address crossed a page |
| br_taken | input | 1 | Conditional branch condition met |
| br_far | input | 1 | Branch target lies in another page |
| len_bytes | output | 2 | Instruction length in bytes |
| busy | output | 1 | High in every cycle of the instruction |
| last_cycle | output | 1 | High in the final cycle of the instruction |

## Verification
`len_bytes`, `busy` and `last_cycle` are combinational in the cycle of the accepted `start`. After that, each later cycle's outputs follow from the counter loaded at the previous edge. The bench therefore drives inputs at the falling edge and samples a quarter period later, before the next rising edge, numbering cycles from 1 at the accepted `start`.

Each flag is driven high only in the cycle the requirement names for sampling: decimal mode in cycle 1, branch flags in cycle 2, and page crossing in the final base cycle. Some cases raise a flag in a different cycle to show it is ignored there. The expected cycle of `last_cycle` comes from the requirement tables. One idle cycle after each instruction confirms that `busy` has dropped.

// File: rtl/insn_cycle_timer.sv
module insn_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic       dec_mode,
  input  logic       page_cross,
  input  logic       br_taken,
  input  logic       br_far,
  output logic [1:0] len_bytes,
  output logic       busy,
  output logic       last_cycle
);

  logic [3:0]       hi, lo;
  logic [CNT_W-1:0] base, total, cnt;
  logic [1:0]       len, len_q;
  logic             pg, br, bra, dec_op;
  logic             pg_q, br_q, bra_q;
  logic             accept, ext;
  logic [CNT_W-1:0] ext_n;

  assign hi = opcode[7:4];
  assign lo = opcode[3:0];

  always_comb begin
    base = CNT_W'(2);
    len  = 2'd2;
    pg   = 1'b0;
    br   = 1'b0;
    bra  = 1'b0;
    case (lo)
      4'h0: begin
        if (hi[0]) br = 1'b1;
        else begin
          case (hi)
            4'h0:      begin len = 2'd1; base = CNT_W'(7); end
            4'h2:      begin len = 2'd3; base = CNT_W'(6); end
            4'h4, 4'h6: begin len = 2'd1; base = CNT_W'(6); end
            4'h8:      begin br = 1'b1; bra = 1'b1; end
            default:   ;
          endcase
        end
      end
      4'h1: begin
        if (hi[0]) begin
          base = (hi == 4'h9) ? CNT_W'(6) : CNT_W'(5);
          pg   = (hi != 4'h9);
        end else base = CNT_W'(6);
      end
      4'h2: base = hi[0] ? CNT_W'(5) : CNT_W'(2);
      4'h3, 4'h7, 4'hB, 4'hF: begin len = 2'd1; base = CNT_W'(1); end
      4'h4: base = (hi < 4'h2) ? CNT_W'(5) : (hi[0] ? CNT_W'(4) : CNT_W'(3));
      4'h5: base = hi[0] ? CNT_W'(4) : CNT_W'(3);
      4'h6: begin
        if (hi[3:2] == 2'b10) base = hi[0] ? CNT_W'(4) : CNT_W'(3);
        else                  base = hi[0] ? CNT_W'(6) : CNT_W'(5);
      end
      4'h8: begin
        len = 2'd1;
        case (hi)
          4'h0, 4'h4: base = CNT_W'(3);
          4'h2, 4'h6: base = CNT_W'(4);
          default:    base = CNT_W'(2);
        endcase
      end
      4'h9: begin
        if (hi[0]) begin
          len  = 2'd3;
          base = (hi == 4'h9) ? CNT_W'(5) : CNT_W'(4);
          pg   = (hi != 4'h9);
        end
      end
      4'hA: begin
        len = 2'd1;
        case (hi)
          4'h5, 4'hD: base = CNT_W'(3);
          4'h7, 4'hF: base = CNT_W'(4);
          default:    base = CNT_W'(2);
        endcase
      end
      4'hC: begin
        len = 2'd3;
        case (hi)
          4'h0, 4'h1, 4'h6, 4'h7: base = CNT_W'(6);
          4'h4:    base = CNT_W'(3);
          4'h5:    base = CNT_W'(8);
          default: base = CNT_W'(4);
        endcase
        pg = (hi == 4'h3) || (hi == 4'hB);
      end
      4'hD: begin
        len  = 2'd3;
        base = (hi == 4'h9) ? CNT_W'(5) : CNT_W'(4);
        pg   = hi[0] && (hi != 4'h9);
      end
      default: begin
        len = 2'd3;
        case (hi)
          4'h8, 4'hA, 4'hB: base = CNT_W'(4);
          4'h9:    base = CNT_W'(5);
          default: base = CNT_W'(6);
        endcase
        pg = (hi == 4'hB);
      end
    endcase
  end

  assign dec_op = (hi[2:1] == 2'b11) && ((lo[1:0] == 2'b01) || (lo == 4'h2 && hi[0]));
  assign total  = base + CNT_W'(dec_op && dec_mode);

  assign accept = start && (cnt == '0);
  assign ext    = (cnt == CNT_W'(1)) &&
                  ((pg_q && page_cross) || (br_q && (br_taken || bra_q)));
  assign ext_n  = (br_q && br_far) ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_q <= 2'd0;
      pg_q  <= 1'b0;
      br_q  <= 1'b0;
      bra_q <= 1'b0;
    end else if (accept) begin
      cnt   <= total - CNT_W'(1);
      len_q <= len;
      pg_q  <= pg;
      br_q  <= br;
      bra_q <= bra;
    end else if (cnt != '0) begin
      cnt <= ext ? ext_n : cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        pg_q  <= 1'b0;
        br_q  <= 1'b0;
        bra_q <= 1'b0;
      end
    end
  end

  assign len_bytes  = accept ? len : len_q;
  assign busy       = accept || (cnt != '0);
  assign last_cycle = (accept && total == CNT_W'(1)) || (cnt == CNT_W'(1) && !ext);

  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_cycle));

  // R4
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_cycle |=> (cnt == '0));

  // R7
  page_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(1) && pg_q && page_cross) |=> last_cycle);

  // R8
  br_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(1) && br_q && !bra_q && !br_taken) |-> last_cycle);

  // R8
  br_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(1) && br_q && (br_taken || bra_q) && br_far) |=> (busy && !last_cycle));

endmodule

// File: tb/test_insn_cycle_timer.sv
module test_insn_cycle_timer;
  localparam int P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       dec_mode = 1'b0;
  logic       page_cross = 1'b0;
  logic       br_taken = 1'b0;
  logic       br_far = 1'b0;
  logic [1:0] len_bytes;
  logic       busy;
  logic       last_cycle;

  int total = 0;
  int bad = 0;
  bit done = 0;

  insn_cycle_timer i_insn_cycle_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dec_mode(dec_mode), .page_cross(page_cross), .br_taken(br_taken),
    .br_far(br_far), .len_bytes(len_bytes), .busy(busy), .last_cycle(last_cycle)
  );

  always #(P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #(P/4);
    check(busy == 0 && last_cycle == 0 && len_bytes == 0, "R1 in reset",
          {busy, last_cycle, len_bytes}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #(P/4);
    check(busy == 0 && last_cycle == 0 && len_bytes == 0, "R1 after reset",
          {busy, last_cycle, len_bytes}, 0);
  endtask

  // fc: cycle in which page_cross/br_taken/br_far carry pc/bt/bf
  task automatic run(input logic [7:0] op, input bit dm, input bit pc, input bit bt,
                     input bit bf, input int fc, input int exp_cyc, input int exp_len,
                     input string req);
    int got = 0;
    int lasts = 0;
    bit busy_ok = 1;
    for (int c = 1; c <= 24; c++) begin
      @(negedge clk);
      start      = (c == 1);
      opcode     = op;
      dec_mode   = (c == 1) ? dm : 1'b0;
      page_cross = (c == fc) ? pc : 1'b0;
      br_taken   = (c == fc) ? bt : 1'b0;
      br_far     = (c == fc) ? bf : 1'b0;
      #(P/4);
      if (c == 1) check(len_bytes == 2'(exp_len), {req, " len"}, len_bytes, exp_len);
      if (!busy) busy_ok = 0;
      if (len_bytes != 2'(exp_len)) busy_ok = 0;
      if (last_cycle) begin
        lasts++;
        got = c;
        break;
      end
    end
    check(got == exp_cyc && lasts == 1, {req, " cycles"}, got, exp_cyc);
    check(busy_ok, {req, " R4 busy/len held"}, busy_ok, 1);
    @(negedge clk);
    start = 1'b0; dec_mode = 1'b0; page_cross = 1'b0; br_taken = 1'b0; br_far = 1'b0;
    #(P/4);
    check(!busy && !last_cycle, {req, " R4 idle after"}, {busy, last_cycle}, 0);
  endtask

  // R5: JSR running, a second start in cycle 3 must be ignored
  task automatic t_ignore();
    int got = 0;
    bit len_ok = 1;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      start  = (c == 1) || (c == 3);
      opcode = (c == 3) ? 8'h03 : 8'h20;
      #(P/4);
      if (len_bytes != 2'd3) len_ok = 0;
      if (last_cycle && got == 0) got = c;
      if (got != 0) break;
    end
    check(got == 6, "R5 start ignored, last at 6", got, 6);
    check(len_ok, "R5 len_bytes unchanged", len_ok, 1);
    @(negedge clk);
    start = 1'b0;
    #(P/4);
    check(!busy, "R5 idle after", busy, 0);
  endtask

  task automatic t_nops();
    run(8'h03, 0, 0, 0, 0, 0, 1, 1, "R2 03");
    run(8'h77, 0, 1, 1, 1, 1, 1, 1, "R2 77");
    run(8'h8F, 0, 0, 0, 0, 0, 1, 1, "R2 8F");
    run(8'hFB, 1, 0, 0, 0, 0, 1, 1, "R2 FB");
    run(8'h42, 0, 0, 0, 0, 0, 2, 2, "R3 42");
    run(8'hE2, 1, 0, 0, 0, 0, 2, 2, "R3 E2");
    run(8'h12, 0, 0, 0, 0, 0, 5, 2, "R3 12");
    run(8'hA2, 0, 0, 0, 0, 0, 2, 2, "R3 A2");
  endtask

  task automatic t_decimal();
    run(8'h69, 0, 0, 0, 0, 0, 2, 2, "R6 69 binary");
    run(8'h69, 1, 0, 0, 0, 0, 3, 2, "R6 69 decimal");
    run(8'hE1, 1, 0, 0, 0, 0, 7, 2, "R6 E1 decimal");
    run(8'hF2, 1, 0, 0, 0, 0, 6, 2, "R6 F2 decimal");
    run(8'hA9, 1, 0, 0, 0, 0, 2, 2, "R6 A9 unaffected");
    run(8'h71, 1, 1, 0, 0, 6, 7, 2, "R6 R7 71 decimal+page");
  endtask

  task automatic t_page();
    run(8'hBD, 0, 1, 0, 0, 4, 5, 3, "R7 BD crossed");
    run(8'hBD, 0, 1, 0, 0, 1, 4, 3, "R7 BD flag off-cycle");
    run(8'hB1, 0, 1, 0, 0, 5, 6, 2, "R7 B1 crossed");
    run(8'hBE, 0, 1, 0, 0, 4, 5, 3, "R7 BE crossed");
    run(8'h3C, 0, 1, 0, 0, 4, 5, 3, "R7 3C crossed");
    run(8'hAD, 0, 1, 0, 0, 4, 4, 3, "R7 AD no penalty");
  endtask

  task automatic t_branch();
    run(8'hD0, 0, 0, 0, 0, 2, 2, 2, "R8 not taken");
    run(8'hD0, 0, 0, 1, 0, 2, 3, 2, "R8 taken near");
    run(8'h10, 0, 0, 1, 1, 2, 4, 2, "R8 taken far");
    run(8'hF0, 0, 0, 0, 1, 2, 2, 2, "R8 far not taken");
    run(8'h30, 0, 0, 1, 1, 1, 2, 2, "R8 flags off-cycle");
    run(8'h80, 0, 0, 0, 0, 2, 3, 2, "R9 near");
    run(8'h80, 0, 0, 0, 1, 2, 4, 2, "R9 far");
  endtask

  task automatic t_flow();
    run(8'h00, 0, 0, 0, 0, 0, 7, 1, "R10 00");
    run(8'h20, 0, 0, 0, 0, 0, 6, 3, "R10 20");
    run(8'h40, 0, 0, 0, 0, 0, 6, 1, "R10 40");
    run(8'h60, 0, 0, 0, 0, 0, 6, 1, "R10 60");
    run(8'h4C, 0, 0, 0, 0, 0, 3, 3, "R12 4C");
    run(8'h6C, 0, 0, 0, 0, 0, 6, 3, "R12 6C");
    run(8'h7C, 0, 0, 0, 0, 0, 6, 3, "R12 7C");
  endtask

  task automatic t_stack();
    run(8'h48, 0, 0, 0, 0, 0, 3, 1, "R11 48");
    run(8'h68, 0, 0, 0, 0, 0, 4, 1, "R11 68");
    run(8'h5A, 0, 0, 0, 0, 0, 3, 1, "R11 5A");
    run(8'h7A, 0, 0, 0, 0, 0, 4, 1, "R11 7A");
    run(8'hDA, 0, 0, 0, 0, 0, 3, 1, "R11 DA");
    run(8'hFA, 0, 0, 0, 0, 0, 4, 1, "R11 FA");
  endtask

  task automatic t_stores();
    run(8'h99, 0, 1, 0, 0, 5, 5, 3, "R13 99");
    run(8'h91, 0, 1, 0, 0, 6, 6, 2, "R13 91");
    run(8'h9D, 0, 1, 0, 0, 5, 5, 3, "R13 9D");
  endtask

  task automatic t_misc();
    run(8'hA9, 0, 0, 0, 0, 0, 2, 2, "R14 A9");
    run(8'hAD, 0, 0, 0, 0, 0, 4, 3, "R14 AD");
    run(8'h0E, 0, 0, 0, 0, 0, 6, 3, "R14 0E");
    run(8'h5C, 0, 0, 0, 0, 0, 8, 3, "R14 5C");
  endtask

  initial begin
    t_reset();
    t_nops();
    t_decimal();
    t_page();
    t_branch();
    t_flow();
    t_stack();
    t_stores();
    t_ignore();
    t_misc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(P * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule